// File: doc/BRIEF.md
# Supply-Mode Power Sequencing Controller

This block decides, once per power-on, whether the system runs from a single supply or from a battery-backed supply. It then gates three outputs that the rest of the chip depends on: an enable for the clock output, an enable for the external power supply, and an active-low CPU reset. The analog comparators stay outside the block. Two digital level inputs take their place: one says the system supply is good, the other says the supply sits above the battery-referenced threshold.

Both level inputs pass through a multi-stage synchronizer and a debounce filter before the control logic sees them. After reset is released, the block waits a settle window equal to the filter latency. At the end of that window it latches the mode from the filtered supply-good level: high selects single-supply mode and low selects battery-backup mode. The mode stays fixed until the next reset.

Software can issue a power-down command, which drops all three outputs. The outputs come back only after the mode's qualifying level has been seen low and then high. In single-supply mode that level is supply-good. In battery-backup mode it is supply-above-battery.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While reset is asserted, and for SYNC_STAGES+DEB_CYCLES cycles after its release, the state reads 00 (reset-pending) and all three outputs are low. The state never returns to 00 without a new reset.
- R2: On the cycle after the settle window, the mode is latched from the filtered supply-good level. High gives single-supply mode (batt_mode_o=0). Low gives battery-backup mode (batt_mode_o=1).
- R3: In single-supply mode the block enters state 01 (operational) straight after the settle window, with clk_out_en_o, psu_en_o and cpu_rst_n_o all high.
- R4: In single-supply mode in state 01, cpu_rst_n_o follows the filtered supply-good level, while clk_out_en_o and psu_en_o stay high.
- R5: A power-down command sampled in state 01 moves the block to state 10 (disabled, awaiting low) on the next cycle. In states 10 and 11 all three outputs are low, including the clock output enable. The command has no effect in states 00, 10 and 11.
- R6: From state 10, a filtered low on the mode's qualifying level moves the block to state 11 (disabled, awaiting high). From state 11, a filtered high moves it back to state 01.
- R7: In battery-backup mode the block sits in state 11 with all outputs low until supply-above-battery is filtered high, and then enters state 01 with all outputs high.
- R8: In battery-backup mode in state 01, a filtered low on supply-above-battery moves the block to state 11, and all outputs go low.
- R9: A change on a level input reaches the control logic only after it has held for DEB_CYCLES consecutive synchronized cycles. Shorter pulses have no effect. The latency from input to filtered level is SYNC_STAGES+DEB_CYCLES cycles.
- R10: If a power-down command and a battery-mode supply fall are both seen in the same cycle in state 01, the power-down wins: the next state is 10, then 11 on the cycle after.
- R11: In battery-backup mode, changes on supply-good have no effect on the state, the mode or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| supply_ok_i | input | 1 | System supply good level (asynchronous) |
| above_batt_i | input | 1 | Supply above battery threshold level (asynchronous) |
| pwr_down_i | input | 1 | Software power-down command, sampled each cycle |
| clk_out_en_o | output | 1 | Clock output enable |
| psu_en_o | output | 1 | Power supply enable |
| cpu_rst_n_o | output | 1 | CPU reset, active low |
| state_o | output | 2 | 00 reset-pending, 01 operational, 10 disabled-awaiting-low, 11 disabled-awaiting-high |
| batt_mode_o | output | 1 | Latched mode: 1 battery-backup, 0 single-supply |

## Verification
A power-down command and a qualified supply fall can land in the same cycle while the block is operational in battery-backup mode. The bench provokes this by dropping supply-above-battery and then raising the command exactly SYNC_STAGES+DEB_CYCLES cycles later, which is the cycle in which the filtered fall first reaches the state machine. It then checks that the state passes through 10 for one cycle before reaching 11, rather than jumping straight to 11. Pulse-width sweeps on both level inputs, across the debounce threshold, check the filter boundary in both modes.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   typedef enum logic [1:0] {
      ST_PEND     = 2'b00,
      ST_OPER     = 2'b01,
      ST_DIS_LOW  = 2'b10,
      ST_DIS_HIGH = 2'b11
   } pwr_state_e;

   localparam int unsigned N_LVL    = 2;
   localparam int unsigned CH_SUPPLY = 0;
   localparam int unsigned CH_ABOVE  = 1;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pwrseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwrseq_debounce.sv
module pwrseq_debounce #(
   parameter int unsigned DEB_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic lvl_o
);

   localparam int unsigned CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("pwrseq_debounce: DEB_CYCLES must be at least 1");
   end

   logic          filt_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         cnt_q  <= '0;
      end else if (lvl_i != filt_q) begin
         if (cnt_q == CNT_LAST) begin
            filt_q <= lvl_i;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         cnt_q <= '0;
      end
   end

   assign lvl_o = filt_q;

   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(DEB_CYCLES));

   assert_hold_on_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i == filt_q) |=> $stable(filt_q));

   assert_change_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_q != $past(filt_q)) |-> ($past(cnt_q) == CNT_LAST));

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
   import pwrseq_pkg::*;
#(
   parameter int unsigned SETTLE = 18
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       good_flt_i,
   input  logic       above_flt_i,
   input  logic       pd_i,
   output pwr_state_e state_o,
   output logic       batt_o
);

   localparam int unsigned PCW = $clog2(SETTLE + 1);
   localparam logic [PCW-1:0] PEND_LAST = PCW'(SETTLE);

   pwr_state_e     state_q, state_d;
   logic           batt_q, batt_d;
   logic [PCW-1:0] pend_q;
   logic           qual;

   // the level that qualifies recovery depends on the latched mode
   assign qual = batt_q ? above_flt_i : good_flt_i;

   always_comb begin
      state_d = state_q;
      batt_d  = batt_q;
      unique case (state_q)
         ST_PEND: begin
            if (pend_q == PEND_LAST) begin
               batt_d = !good_flt_i;
               if (good_flt_i || above_flt_i) state_d = ST_OPER;
               else                           state_d = ST_DIS_HIGH;
            end
         end
         ST_OPER: begin
            if (pd_i)                state_d = ST_DIS_LOW;
            else if (batt_q && !qual) state_d = ST_DIS_HIGH;
         end
         ST_DIS_LOW: begin
            if (!qual) state_d = ST_DIS_HIGH;
         end
         ST_DIS_HIGH: begin
            if (qual) state_d = ST_OPER;
         end
         default: state_d = ST_PEND;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PEND;
         batt_q  <= 1'b0;
         pend_q  <= '0;
      end else begin
         state_q <= state_d;
         batt_q  <= batt_d;
         if (state_q == ST_PEND && pend_q != PEND_LAST) pend_q <= pend_q + 1'b1;
      end
   end

   assign state_o = state_q;
   assign batt_o  = batt_q;

   assert_pd_to_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OPER && pd_i) |=> (state_q == ST_DIS_LOW));

   assert_batt_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OPER && batt_q && !above_flt_i && !pd_i) |=> (state_q == ST_DIS_HIGH));

   assert_wait_high_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DIS_HIGH) |=> (state_q == ST_DIS_HIGH || state_q == ST_OPER));

   assert_no_repend_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_PEND) |=> (state_q != ST_PEND));

   assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_PEND) |=> $stable(batt_q));

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
   import pwrseq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEB_CYCLES  = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok_i,
   input  logic       above_batt_i,
   input  logic       pwr_down_i,
   output logic       clk_out_en_o,
   output logic       psu_en_o,
   output logic       cpu_rst_n_o,
   output logic [1:0] state_o,
   output logic       batt_mode_o
);

   localparam int unsigned SETTLE = SYNC_STAGES + DEB_CYCLES;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwrseq_ctrl: SYNC_STAGES must be at least 2");
   end
   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("pwrseq_ctrl: DEB_CYCLES must be at least 1");
   end

   logic [N_LVL-1:0] raw_lvl, sync_lvl, flt_lvl;
   pwr_state_e       state;
   logic             batt;
   logic             live;

   assign raw_lvl[CH_SUPPLY] = supply_ok_i;
   assign raw_lvl[CH_ABOVE]  = above_batt_i;

   for (genvar c = 0; c < N_LVL; c++) begin : g_lvl
      pwrseq_sync #(.STAGES(SYNC_STAGES)) sync_i (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (raw_lvl[c]),
         .q_o   (sync_lvl[c])
      );
      pwrseq_debounce #(.DEB_CYCLES(DEB_CYCLES)) deb_i (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl_i (sync_lvl[c]),
         .lvl_o (flt_lvl[c])
      );
   end

   pwrseq_fsm #(.SETTLE(SETTLE)) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .good_flt_i  (flt_lvl[CH_SUPPLY]),
      .above_flt_i (flt_lvl[CH_ABOVE]),
      .pd_i        (pwr_down_i),
      .state_o     (state),
      .batt_o      (batt)
   );

   assign live         = (state == ST_OPER);
   assign clk_out_en_o = live;
   assign psu_en_o     = live;
   assign cpu_rst_n_o  = live && (batt || flt_lvl[CH_SUPPLY]);
   assign state_o      = state;
   assign batt_mode_o  = batt;

   assert_pend_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00) |-> !(clk_out_en_o || psu_en_o || cpu_rst_n_o));

   assert_dis_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      state_o[1] |-> !(clk_out_en_o || psu_en_o || cpu_rst_n_o));

   assert_single_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b01 && !batt_mode_o) |-> (clk_out_en_o && psu_en_o));

endmodule

// File: tb/pwrseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwrseq_ctrl_tb_top;

   localparam int SYNC = 2;
   localparam int DEB  = 4;
   localparam int LAT  = SYNC + DEB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_ok = 1'b0;
   logic       above_batt = 1'b0;
   logic       pwr_down = 1'b0;
   logic       clk_en, psu_en, cpu_rst_n, batt_mode;
   logic [1:0] state;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   pwrseq_ctrl #(.SYNC_STAGES(SYNC), .DEB_CYCLES(DEB)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .supply_ok_i  (supply_ok),
      .above_batt_i (above_batt),
      .pwr_down_i   (pwr_down),
      .clk_out_en_o (clk_en),
      .psu_en_o     (psu_en),
      .cpu_rst_n_o  (cpu_rst_n),
      .state_o      (state),
      .batt_mode_o  (batt_mode)
   );

   task automatic chk(input int act, input int exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // outputs packed as clk_en*4 + psu_en*2 + cpu_rst_n
   function automatic int outs();
      return int'({clk_en, psu_en, cpu_rst_n});
   endfunction

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic good, input logic above);
      @(negedge clk);
      rst_n      = 1'b0;
      supply_ok  = good;
      above_batt = above;
      pwr_down   = 1'b0;
      wait_n(4);
      rst_n = 1'b1;
   endtask

   task automatic pulse_pd();
      pwr_down = 1'b1;
      @(negedge clk);
      pwr_down = 1'b0;
   endtask

   initial begin : main
      logic saw;

      // ---- single-supply start
      @(negedge clk);
      supply_ok = 1'b1; above_batt = 1'b1;
      wait_n(3);
      chk(int'(state), 0, "R1 state in reset");
      chk(outs(), 0, "R1 outputs in reset");
      rst_n = 1'b1;
      wait_n(LAT);
      chk(int'(state), 0, "R1 still pending at end of settle");
      chk(outs(), 0, "R1 outputs low during settle");
      wait_n(1);
      chk(int'(state), 1, "R3 operational after settle");
      chk(int'(batt_mode), 0, "R2 single mode latched");
      chk(outs(), 7, "R3 all outputs enabled");

      // R4: cpu reset follows supply-good
      supply_ok = 1'b0;
      wait_n(LAT - 1);
      chk(int'(cpu_rst_n), 1, "R4 cpu reset before filter latency");
      wait_n(1);
      chk(outs(), 6, "R4 cpu reset low, others high");
      chk(int'(state), 1, "R4 stays operational");
      supply_ok = 1'b1;
      wait_n(LAT + 1);
      chk(outs(), 7, "R4 cpu reset released again");

      // R9: pulse-width sweep on supply-good
      for (int w = 1; w <= DEB + 2; w++) begin
         supply_ok = 1'b0;
         saw = 1'b0;
         repeat (w) begin @(negedge clk); if (!cpu_rst_n) saw = 1'b1; end
         supply_ok = 1'b1;
         repeat (LAT + DEB + 4) begin @(negedge clk); if (!cpu_rst_n) saw = 1'b1; end
         chk(int'(saw), (w >= DEB) ? 1 : 0, $sformatf("R9 single pulse width %0d", w));
         chk(int'(cpu_rst_n), 1, "R9 settled high after pulse");
      end

      // R5: power-down
      pulse_pd();
      chk(int'(state), 2, "R5 power-down enters state 10");
      chk(outs(), 0, "R5 power-down drops outputs incl. clock enable");
      wait_n(10);
      chk(int'(state), 2, "R6 waits for low while supply high");
      pulse_pd();
      chk(int'(state), 2, "R5 command ignored in state 10");

      // R6: low-then-high recovery
      supply_ok = 1'b0;
      wait_n(LAT);
      chk(int'(state), 2, "R6 not yet seen low");
      wait_n(1);
      chk(int'(state), 3, "R6 state 11 after low");
      pulse_pd();
      chk(int'(state), 3, "R5 command ignored in state 11");
      supply_ok = 1'b1;
      wait_n(LAT + 1);
      chk(int'(state), 1, "R6 recovered to operational");
      chk(outs(), 7, "R6 outputs re-enabled");

      // ---- power-down ignored during settle (R5)
      do_reset(1'b1, 1'b0);
      pwr_down = 1'b1;
      wait_n(3);
      pwr_down = 1'b0;
      wait_n(LAT - 2);
      chk(int'(state), 1, "R5 command ignored while pending");

      // ---- battery start, supply below threshold
      do_reset(1'b0, 1'b0);
      wait_n(LAT + 1);
      chk(int'(batt_mode), 1, "R2 battery mode latched");
      chk(int'(state), 3, "R7 held disabled awaiting supply");
      chk(outs(), 0, "R7 outputs low");
      above_batt = 1'b1;
      wait_n(LAT);
      chk(int'(state), 3, "R7 still disabled before latency");
      wait_n(1);
      chk(int'(state), 1, "R7 operational after supply rises");
      chk(outs(), 7, "R7 outputs enabled");

      // R11: supply-good has no effect in battery mode
      supply_ok = 1'b1;
      wait_n(LAT + 4);
      chk(int'(state) * 16 + int'(batt_mode) * 8 + outs(), 16 + 8 + 7, "R11 supply-good high ignored");
      supply_ok = 1'b0;
      wait_n(LAT + 4);
      chk(int'(state) * 16 + int'(batt_mode) * 8 + outs(), 16 + 8 + 7, "R11 supply-good low ignored");

      // R8: supply falls below threshold
      above_batt = 1'b0;
      wait_n(LAT + 1);
      chk(int'(state), 3, "R8 disabled on supply fall");
      chk(outs(), 0, "R8 outputs low");
      above_batt = 1'b1;
      wait_n(LAT + 1);
      chk(int'(state), 1, "R8 back to operational");

      // R9: pulse-width sweep on above-battery
      for (int w = 1; w <= DEB + 2; w++) begin
         above_batt = 1'b0;
         saw = 1'b0;
         repeat (w) begin @(negedge clk); if (state == 2'b11) saw = 1'b1; end
         above_batt = 1'b1;
         repeat (LAT + DEB + 4) begin @(negedge clk); if (state == 2'b11) saw = 1'b1; end
         chk(int'(saw), (w >= DEB) ? 1 : 0, $sformatf("R9 battery pulse width %0d", w));
         chk(int'(state), 1, "R9 battery settled operational");
      end

      // R10: power-down and supply fall in the same cycle
      above_batt = 1'b0;
      wait_n(LAT);
      chk(int'(state), 1, "R10 operational before collision");
      pulse_pd();
      chk(int'(state), 2, "R10 power-down wins over fall");
      wait_n(1);
      chk(int'(state), 3, "R10 then awaiting high");
      above_batt = 1'b1;
      wait_n(LAT + 1);
      chk(int'(state), 1, "R6 battery recovery after collision");

      // R6 in battery mode: power-down with supply held high
      pulse_pd();
      chk(int'(state), 2, "R5 battery power-down");
      wait_n(8);
      chk(int'(state), 2, "R6 battery waits for low");
      above_batt = 1'b0;
      wait_n(LAT + 1);
      chk(int'(state), 3, "R6 battery saw low");
      above_batt = 1'b1;
      wait_n(LAT + 1);
      chk(int'(state), 1, "R6 battery recovered");

      // ---- battery start with supply already above threshold
      do_reset(1'b0, 1'b1);
      wait_n(LAT);
      chk(int'(state), 0, "R1 battery settle pending");
      wait_n(1);
      chk(int'(batt_mode) * 8 + int'(state) * 16 + outs(), 8 + 16 + 7, "R2 battery start operational");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired, all requirements unfinished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule